// File: doc/BRIEF.md
# Event Interrupter Router

This block sits between the event producer of a USB host-controller core and the interrupt delivery logic. Each completed event arrives over a valid/ready handshake together with an interrupter target index and a flag saying whether the event wants an interrupt. The block decides which of its interrupters receives the event, bumps that interrupter's pending-event counter, and, when signalling is allowed, sets the interrupter's pending flag. It then drives either a one-cycle message vector pulse (when message-signalled interrupts are on) or a single level-sensitive pin interrupt (when they are off).

The routing decision depends on how many interrupters the instance has and on a compatibility bit. With a single interrupter the target field is disregarded. With several interrupters the target is honoured whatever the message-interrupt state, so events aimed at interrupters other than 0 are posted but stay silent in pin mode. When the compatibility bit is set and both message-interrupt kinds are off, every event is steered to interrupter 0 so that pin-mode software still sees them. Software acknowledges a pending flag with a write-one-to-clear strobe.

Top module: `evt_intr_router`

## Requirements
- R1: Reset clears every pending flag and every pending counter and holds the vector pulse and the pin interrupt low.
- R2: With more than one interrupter and the compatibility bit clear, an accepted event whose target is below the interrupter count increments the counter of exactly that target, whether message interrupts are on or off.
- R3: With the compatibility bit set and both message-interrupt enables low, every accepted event goes to interrupter 0 regardless of its target (including targets past the last interrupter); if either message enable is high the target is honoured as in R2.
- R4: When the target is honoured and is greater than or equal to the interrupter count, the event is accepted (ready stays high) and changes no counter and no pending flag.
- R5: An instance built with one interrupter routes every event to interrupter 0, whatever its target.
- R6: A routed event sets the destination's pending flag only if it wants an interrupt, the global enable is high, the destination's own enable is high, and either a message interrupt is enabled or the destination is interrupter 0; the counter increments in every case. At most one pending flag rises per cycle.
- R7: The pin interrupt is low while any message interrupt is enabled; otherwise it equals global enable AND interrupter 0's enable AND interrupter 0's pending flag, taken one clock earlier.
- R8: With a message interrupt enabled, a pending flag going from 0 to 1 produces a vector pulse lasting one cycle, in the same cycle the flag is first visible, carrying that interrupter's index; an event hitting an already-set flag produces no pulse.
- R9: A one on bit i of the clear strobe clears pending flag i at the next edge; if an event sets the same flag in that cycle, the set wins.
- R10: When the destination counter is at its maximum value, ready is low, the event is not taken and the counter holds; events to other destinations are still taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event can be taken this cycle |
| ev_target | input | TGT_W | Requested interrupter index |
| ev_need_irq | input | 1 | Event wants an interrupt |
| glob_en | input | 1 | Global interrupter enable |
| intr_en | input | N_INTR | Per-interrupter interrupt enable |
| msi_on | input | 1 | Message interrupts enabled |
| msix_on | input | 1 | Extended message interrupts enabled |
| compat_mode | input | 1 | Steer all events to interrupter 0 in pin mode |
| ip_clear | input | N_INTR | Write-one-to-clear strobe for pending flags |
| ip_flags | output | N_INTR | Pending flag per interrupter |
| pend_cnt | output | N_INTR*CNT_W | Pending-event counters, interrupter i at bits i*CNT_W upward |
| vec_valid | output | 1 | One-cycle message vector pulse |
| vec_index | output | ID_W | Interrupter index of the pulse |
| pin_irq | output | 1 | Level-sensitive pin interrupt |

## Verification
Counters, pending flags and the vector pulse are all registered at the edge that accepts the event, so the bench reads them at the falling edge right after that acceptance edge. The pin interrupt is one register further down, derived from the flags already in place, so it is read one full cycle later, and the clear test confirms it still shows the old level at the first falling edge after a clear and drops only one cycle after that. Ready is combinational from the offered event and is read shortly after the inputs change, before the edge that would take the event.

// File: rtl/evr_pkg.sv
package evr_pkg;
  typedef enum logic [1:0] {
    RT_TARGET = 2'd0,
    RT_FORCE0 = 2'd1,
    RT_DROP   = 2'd2
  } route_kind_e;
endpackage

// File: rtl/evr_route.sv
module evr_route
  import evr_pkg::*;
#(
  parameter int N_INTR = 16,
  parameter int TGT_W  = 5,
  parameter int ID_W   = 4
) (
  input  logic [TGT_W-1:0] ev_target,
  input  logic             msi_on,
  input  logic             msix_on,
  input  logic             compat_mode,
  output route_kind_e      kind,
  output logic [ID_W-1:0]  dest,
  output logic             msg_mode
);
  localparam bit SINGLE = (N_INTR == 1);

  always_comb begin
    msg_mode = msi_on | msix_on;
    kind     = RT_TARGET;
    dest     = ev_target[ID_W-1:0];
    if (SINGLE || (compat_mode && !msg_mode)) begin
      kind = RT_FORCE0;
      dest = '0;
    end else if (32'(ev_target) >= 32'(N_INTR)) begin
      kind = RT_DROP;
      dest = '0;
    end
  end
endmodule

// File: rtl/evr_slot.sv
module evr_slot #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             need,
  input  logic             allow,
  input  logic             clr,
  output logic             ip,
  output logic [CNT_W-1:0] cnt,
  output logic             rise,
  output logic             full
);
  logic set_now;

  assign set_now = hit & need & allow;
  assign rise    = set_now & ~ip;
  assign full    = &cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ip  <= 1'b0;
      cnt <= '0;
    end else begin
      if (hit) cnt <= cnt + 1'b1;
      if (set_now)  ip <= 1'b1;
      else if (clr) ip <= 1'b0;
    end
  end
endmodule

// File: rtl/evr_signal.sv
module evr_signal #(
  parameter int N_INTR = 16,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_mode,
  input  logic              glob_en,
  input  logic [N_INTR-1:0] intr_en,
  input  logic [N_INTR-1:0] ip,
  input  logic [N_INTR-1:0] rise,
  output logic              vec_valid,
  output logic [ID_W-1:0]   vec_index,
  output logic              pin_irq
);
  localparam logic [N_INTR-1:0] PIN_ELIG = N_INTR'(1);

  logic [ID_W-1:0] rise_idx;

  always_comb begin
    rise_idx = '0;
    for (int i = 0; i < N_INTR; i++) begin
      if (rise[i]) rise_idx = ID_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid <= 1'b0;
      vec_index <= '0;
      pin_irq   <= 1'b0;
    end else begin
      vec_valid <= msg_mode & (|rise);
      vec_index <= rise_idx;
      pin_irq   <= ~msg_mode & glob_en & (|(ip & intr_en & PIN_ELIG));
    end
  end
endmodule

// File: rtl/evt_intr_router.sv
module evt_intr_router
  import evr_pkg::*;
#(
  parameter int N_INTR = 16,
  parameter int TGT_W  = 5,
  parameter int CNT_W  = 8,
  parameter int ID_W   = (N_INTR > 1) ? $clog2(N_INTR) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ev_valid,
  output logic                    ev_ready,
  input  logic [TGT_W-1:0]        ev_target,
  input  logic                    ev_need_irq,
  input  logic                    glob_en,
  input  logic [N_INTR-1:0]       intr_en,
  input  logic                    msi_on,
  input  logic                    msix_on,
  input  logic                    compat_mode,
  input  logic [N_INTR-1:0]       ip_clear,
  output logic [N_INTR-1:0]       ip_flags,
  output logic [N_INTR*CNT_W-1:0] pend_cnt,
  output logic                    vec_valid,
  output logic [ID_W-1:0]         vec_index,
  output logic                    pin_irq
);
  route_kind_e       kind;
  logic [ID_W-1:0]   dest;
  logic              msg_mode;
  logic [N_INTR-1:0] full;
  logic [N_INTR-1:0] rise;
  logic              take;

  evr_route #(.N_INTR(N_INTR), .TGT_W(TGT_W), .ID_W(ID_W)) u_route (
    .ev_target   (ev_target),
    .msi_on      (msi_on),
    .msix_on     (msix_on),
    .compat_mode (compat_mode),
    .kind        (kind),
    .dest        (dest),
    .msg_mode    (msg_mode)
  );

  assign ev_ready = ~((kind != RT_DROP) & full[dest]);
  assign take     = ev_valid & ev_ready & (kind != RT_DROP);

  for (genvar i = 0; i < N_INTR; i++) begin : g_slot
    logic hit_i;
    logic allow_i;
    assign hit_i   = take & (dest == ID_W'(i));
    assign allow_i = glob_en & intr_en[i] & (msg_mode | (i == 0));
    evr_slot #(.CNT_W(CNT_W)) u_slot (
      .clk   (clk),
      .rst   (rst),
      .hit   (hit_i),
      .need  (ev_need_irq),
      .allow (allow_i),
      .clr   (ip_clear[i]),
      .ip    (ip_flags[i]),
      .cnt   (pend_cnt[i*CNT_W +: CNT_W]),
      .rise  (rise[i]),
      .full  (full[i])
    );
  end

  evr_signal #(.N_INTR(N_INTR), .ID_W(ID_W)) u_signal (
    .clk       (clk),
    .rst       (rst),
    .msg_mode  (msg_mode),
    .glob_en   (glob_en),
    .intr_en   (intr_en),
    .ip        (ip_flags),
    .rise      (rise),
    .vec_valid (vec_valid),
    .vec_index (vec_index),
    .pin_irq   (pin_irq)
  );
endmodule

// File: rtl/evt_intr_router_chk.sv
module evt_intr_router_chk #(
  parameter int N_INTR = 16,
  parameter int TGT_W  = 5,
  parameter int CNT_W  = 8,
  parameter int ID_W   = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    ev_valid,
  input logic                    ev_ready,
  input logic [TGT_W-1:0]        ev_target,
  input logic                    msi_on,
  input logic                    msix_on,
  input logic                    compat_mode,
  input logic [N_INTR-1:0]       ip_clear,
  input logic [N_INTR-1:0]       ip_flags,
  input logic [N_INTR*CNT_W-1:0] pend_cnt,
  input logic                    vec_valid,
  input logic [ID_W-1:0]         vec_index,
  input logic                    pin_irq
);
  logic honour_tgt;
  assign honour_tgt = (N_INTR != 1) && !(compat_mode && !msi_on && !msix_on);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (ip_flags == '0 && pend_cnt == '0 && !vec_valid && !pin_irq));

  a_r4_drop_no_change: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && honour_tgt && 32'(ev_target) >= 32'(N_INTR) && ip_clear == '0)
    |=> ($stable(ip_flags) && $stable(pend_cnt)));

  a_r10_stall_holds: assert property (@(posedge clk) disable iff (rst)
    !ev_ready |=> $stable(pend_cnt));

  a_r6_one_rise: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ip_flags & ~$past(ip_flags)));

  a_r8_vec_flag_set: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> ip_flags[vec_index]);

  a_r8_vec_msg_only: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(msi_on || msix_on));

  a_r7_pin_quiet_msg: assert property (@(posedge clk) disable iff (rst)
    $past(msi_on || msix_on) |-> !pin_irq);
endmodule

bind evt_intr_router evt_intr_router_chk #(
  .N_INTR(N_INTR), .TGT_W(TGT_W), .CNT_W(CNT_W), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .ev_target(ev_target), .msi_on(msi_on), .msix_on(msix_on),
  .compat_mode(compat_mode), .ip_clear(ip_clear), .ip_flags(ip_flags),
  .pend_cnt(pend_cnt), .vec_valid(vec_valid), .vec_index(vec_index),
  .pin_irq(pin_irq)
);

// File: tb/test_evt_intr_router.sv
`timescale 1ns/1ps
module test_evt_intr_router;
  localparam int N  = 16;
  localparam int TW = 5;
  localparam int CW = 4;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          ev_valid = 0, ev_need = 0, glob_en = 0, msi = 0, msix = 0, compat = 0;
  logic [TW-1:0] ev_target = '0;
  logic [N-1:0]  intr_en = '0, ip_clear = '0;
  logic          ev_ready, vec_valid, pin_irq;
  logic [N-1:0]  ip_flags;
  logic [N*CW-1:0] pend_cnt;
  logic [IW-1:0] vec_index;

  evt_intr_router #(.N_INTR(N), .TGT_W(TW), .CNT_W(CW)) i_evt_intr_router (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_target(ev_target), .ev_need_irq(ev_need), .glob_en(glob_en),
    .intr_en(intr_en), .msi_on(msi), .msix_on(msix), .compat_mode(compat),
    .ip_clear(ip_clear), .ip_flags(ip_flags), .pend_cnt(pend_cnt),
    .vec_valid(vec_valid), .vec_index(vec_index), .pin_irq(pin_irq)
  );

  // single-interrupter instance for R5
  logic          s_valid = 0;
  logic [TW-1:0] s_target = '0;
  logic          s_ready, s_ip, s_vec, s_pin;
  logic [CW-1:0] s_cnt;
  logic [0:0]    s_idx;

  evt_intr_router #(.N_INTR(1), .TGT_W(TW), .CNT_W(CW)) i_evt_intr_router_single (
    .clk(clk), .rst(rst), .ev_valid(s_valid), .ev_ready(s_ready),
    .ev_target(s_target), .ev_need_irq(1'b1), .glob_en(1'b1),
    .intr_en(1'b1), .msi_on(1'b1), .msix_on(1'b0), .compat_mode(1'b0),
    .ip_clear(1'b0), .ip_flags(s_ip), .pend_cnt(s_cnt),
    .vec_valid(s_vec), .vec_index(s_idx), .pin_irq(s_pin)
  );

  int n_chk = 0, n_bad = 0;
  int mcnt [N];

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_counts(input string req);
    for (int i = 0; i < N; i++) chk(req, int'(pend_cnt[i*CW +: CW]), mcnt[i]);
  endtask

  // [19]msi [18]msix [17]compat [16]need [15:11]target
  // [10]drop [9:6]dest [5]ip set [4]vec pulse [3]pin   [2:0] unused
  localparam logic [19:0] VEC [12] = '{
    {4'b1001, 5'd5,  1'b0, 4'd5,  3'b110, 3'b0},  // R2 R8 msi
    {4'b0101, 5'd9,  1'b0, 4'd9,  3'b110, 3'b0},  // R2 R8 msix
    {4'b0001, 5'd3,  1'b0, 4'd3,  3'b000, 3'b0},  // R2 R6 pin mode, silent
    {4'b0001, 5'd0,  1'b0, 4'd0,  3'b101, 3'b0},  // R6 R7 pin mode, ring 0
    {4'b0011, 5'd7,  1'b0, 4'd0,  3'b101, 3'b0},  // R3 redirect
    {4'b1011, 5'd7,  1'b0, 4'd7,  3'b110, 3'b0},  // R3 honoured with msi
    {4'b0001, 5'd20, 1'b1, 4'd0,  3'b000, 3'b0},  // R4 drop
    {4'b1001, 5'd16, 1'b1, 4'd0,  3'b000, 3'b0},  // R4 drop
    {4'b0011, 5'd20, 1'b0, 4'd0,  3'b101, 3'b0},  // R3 out-of-range redirected
    {4'b1000, 5'd2,  1'b0, 4'd2,  3'b000, 3'b0},  // R6 no interrupt wanted
    {4'b0101, 5'd15, 1'b0, 4'd15, 3'b110, 3'b0},  // R2 R8 last index
    {4'b0000, 5'd0,  1'b0, 4'd0,  3'b000, 3'b0}   // R6 R7 no interrupt wanted
  };

  task automatic send(input logic [TW-1:0] t, input logic need);
    ev_valid = 1; ev_target = t; ev_need = need;
    cyc();
    ev_valid = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mcnt[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk("R1 ip", int'(ip_flags), 0);
    chk("R1 pin", int'(pin_irq), 0);
    chk("R1 vec", int'(vec_valid), 0);
    chk_counts("R1 cnt");
    rst = 0;

    for (int k = 0; k < 12; k++) begin
      logic [19:0] v;
      v = VEC[k];
      glob_en = 1; intr_en = '1; ip_clear = '1;
      msi = v[19]; msix = v[18]; compat = v[17];
      cyc();
      ip_clear = '0;
      ev_valid = 1; ev_target = v[15:11]; ev_need = v[16];
      #1 chk($sformatf("vec %0d ready", k), int'(ev_ready), 1);
      cyc();
      ev_valid = 0;
      if (!v[10]) mcnt[v[9:6]]++;
      chk($sformatf("vec %0d ip", k), int'(ip_flags), v[5] ? (1 << v[9:6]) : 0);
      chk($sformatf("vec %0d pulse", k), int'(vec_valid), int'(v[4]));
      if (v[4]) chk($sformatf("vec %0d index", k), int'(vec_index), int'(v[9:6]));
      chk_counts($sformatf("vec %0d cnt", k));
      cyc();
      chk($sformatf("vec %0d pin", k), int'(pin_irq), int'(v[3]));
      chk($sformatf("vec %0d pulse width", k), int'(vec_valid), 0);
    end

    // R6 global enable off
    ip_clear = '1; msi = 1; msix = 0; compat = 0; glob_en = 0;
    cyc(); ip_clear = '0;
    send(5'd5, 1'b1); mcnt[5]++;
    chk("R6 glob off ip", int'(ip_flags), 0);
    chk("R6 glob off pulse", int'(vec_valid), 0);
    chk_counts("R6 glob off cnt");
    // R6 own enable off
    glob_en = 1; intr_en[5] = 0;
    send(5'd5, 1'b1); mcnt[5]++;
    chk("R6 ien off ip", int'(ip_flags), 0);
    chk_counts("R6 ien off cnt");
    intr_en = '1;
    // R8 rise gives pulse, repeat gives none
    send(5'd5, 1'b1); mcnt[5]++;
    chk("R8 first pulse", int'(vec_valid), 1);
    chk("R8 first index", int'(vec_index), 5);
    send(5'd5, 1'b1); mcnt[5]++;
    chk("R8 repeat pulse", int'(vec_valid), 0);
    chk("R8 repeat ip", int'(ip_flags), 1 << 5);
    chk_counts("R8 cnt");
    // R9 set wins over clear, then clear alone
    ip_clear[5] = 1;
    send(5'd5, 1'b1); mcnt[5]++;
    ip_clear = '0;
    chk("R9 set wins", int'(ip_flags), 1 << 5);
    ip_clear[5] = 1; cyc(); ip_clear = '0;
    chk("R9 clear", int'(ip_flags), 0);

    // R7 pin timing around a clear
    msi = 0;
    send(5'd0, 1'b1); mcnt[0]++;
    chk("R7 pin not yet", int'(pin_irq), 0);
    cyc();
    chk("R7 pin up", int'(pin_irq), 1);
    ip_clear[0] = 1; cyc(); ip_clear = '0;
    chk("R7 pin lags clear", int'(pin_irq), 1);
    cyc();
    chk("R7 pin down", int'(pin_irq), 0);
    // R7 enabling msi silences the pin
    send(5'd0, 1'b1); mcnt[0]++;
    cyc();
    chk("R7 pin again", int'(pin_irq), 1);
    msi = 1; cyc(); cyc();
    chk("R7 pin quiet in msg mode", int'(pin_irq), 0);
    msi = 0;

    // R10 saturation back-pressure on interrupter 4
    msi = 1;
    while (mcnt[4] < 15) begin
      send(5'd4, 1'b0); mcnt[4]++;
    end
    chk_counts("R10 filled");
    ev_valid = 1; ev_target = 5'd4; ev_need = 0;
    #1 chk("R10 ready low", int'(ev_ready), 0);
    cyc(); ev_valid = 0;
    chk("R10 held", int'(pend_cnt[4*CW +: CW]), 15);
    ev_valid = 1; ev_target = 5'd6;
    #1 chk("R10 other ready", int'(ev_ready), 1);
    cyc(); ev_valid = 0; mcnt[6]++;
    chk_counts("R10 other taken");

    // R5 single interrupter instance
    s_valid = 1; s_target = 5'd7; cyc(); s_valid = 0;
    chk("R5 cnt", int'(s_cnt), 1);
    chk("R5 ip", int'(s_ip), 1);
    chk("R5 pulse", int'(s_vec), 1);
    chk("R5 index", int'(s_idx), 0);
    s_valid = 1; s_target = 5'd20; cyc(); s_valid = 0;
    chk("R5 far target", int'(s_cnt), 2);

    // R1 reset mid-run
    rst = 1; cyc(); cyc(); rst = 0;
    for (int i = 0; i < N; i++) mcnt[i] = 0;
    chk("R1 ip after", int'(ip_flags), 0);
    chk("R1 single cnt", int'(s_cnt), 0);
    chk_counts("R1 cnt after");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule